// File: doc/BRIEF.md
# Strobe-Clocked Serial Register Slave

This block gives a host access to a small register file over four slow, software-toggled lines: a clear line, a strobe line, a host-to-slave data line and a slave-to-host data line. There is no chip select and no dedicated serial clock. The block samples all host lines with its own system clock through two-flop synchronizers and finds strobe rising edges by comparing successive synchronized samples. Each rising edge captures one input bit and advances the output bit stream.

A command frame opens with a one-bit direction flag, followed by a 7-bit register address, most significant bit first. A write frame then carries a 16-bit value, most significant bit first, and commits it with a single-cycle internal write pulse. A read frame fetches the addressed register as soon as the address is complete and returns it on the output line, most significant bit first, one bit per strobe rising edge. Raising the clear line discards any partial frame and realigns framing.

The register file holds two read-only identification words (a platform word whose low byte is a manufacturer code, and a firmware word split into four 4-bit fields) plus a parameterised bank of read/write scratch registers.

Top module: `strobe_reg_slave`

## Requirements
- R1: After reset dataOut is 0 and every read/write register reads back as 16'h0000.
- R2: Bits are taken from dataIn only at strobe rising edges; a frame is a flag bit (1 = read, 0 = write), then a 7-bit address MSB first, then for writes 16 data bits MSB first; dataIn changes while strobe is high have no effect.
- R3: A write frame updates the addressed read/write register (addresses 2 to 5) with one single-cycle write pulse that follows the edge carrying the last data bit.
- R4: On a read, bit 15 of the register is on dataOut once the last address bit is taken; after the k-th data-phase strobe rising edge (k = 1..16) dataOut shows bit 16-k, and it changes only on a strobe edge, a fetch or a clear.
- R5: Address 0 reads 16'h025A (low byte 8'h5A is the manufacturer code); address 1 reads 16'h3142, laid out as build [15:12] = 3, major [11:8] = 1, minor [7:4] = 4, patch [3:0] = 2.
- R6: Writes to addresses 0 and 1 and to unmapped addresses (6 to 127) change no register; unmapped addresses read 16'h0000.
- R7: While clearIn is high, strobe edges are ignored, no write or fetch happens and dataOut is 0; after clearIn falls the next strobe rising edge is taken as a flag bit.
- R8: After a complete frame the slave is idle; the next strobe rising edge starts a new frame and shifts a 0 onto dataOut.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clearIn | input | 1 | Host clear line, active high, asynchronous to clk |
| strobeIn | input | 1 | Host strobe line; rising edges move one bit |
| dataIn | input | 1 | Host-to-slave serial data |
| dataOut | output | 1 | Slave-to-host serial data |

## Verification
The assertions take for granted that each strobe level is held for at least three system clocks, so that no rising edge lands in the one-cycle decode or commit step, and that dataIn is settled when strobe rises. The bench holds each strobe level for six clocks and changes dataIn only during the low phase, except in the glitch test, which flips dataIn four clocks after the rising edge, after the synchronized sample has been taken. Clear pulses are held for several clocks and always cover whole strobe phases.

// File: rtl/strobe_reg_pkg.sv
package strobe_reg_pkg;

  // One-hot-ish action strobes from control to datapath
  typedef struct packed {
    logic shiftIn;    // capture dataIn into the input shifter
    logic shiftOut;   // advance the output shifter, filling with zero
    logic latchAddr;  // hold the header address for the rest of the frame
    logic loadOut;    // load the fetched register into the output shifter
    logic wrEn;       // single-cycle register write
    logic clearAll;   // discard frame state
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_HDR    = 3'd0,
    ST_DECODE = 3'd1,
    ST_WDATA  = 3'd2,
    ST_COMMIT = 3'd3,
    ST_RDATA  = 3'd4
  } linkState_e;

endpackage

// File: rtl/strobe_reg_sync.sv
module strobe_reg_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] asyncIn,
  output logic [LINES-1:0] syncOut
);

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn[g]};
    end
    assign syncOut[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/strobe_reg_ctrl.sv
module strobe_reg_ctrl
  import strobe_reg_pkg::*;
#(
  parameter int HDR_BITS = 8,
  parameter int DATA_W   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clearLvl,
  input  logic        stbRise,
  input  logic        hdrIsRead,
  output ctrlStrobe_t stb
);

  localparam int MAX_BITS = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;
  localparam int CNT_W    = $clog2(MAX_BITS);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  linkState_e       state, nState;
  logic [CNT_W-1:0] cnt, nCnt;

  always_comb begin
    stb    = '0;
    nState = state;
    nCnt   = cnt;
    if (clearLvl) begin
      stb.clearAll = 1'b1;
      nState       = ST_HDR;
      nCnt         = '0;
    end else begin
      unique case (state)
        ST_HDR: begin
          if (stbRise) begin
            stb.shiftIn  = 1'b1;
            stb.shiftOut = 1'b1;
            if (cnt == HDR_LAST) begin
              nCnt   = '0;
              nState = ST_DECODE;
            end else begin
              nCnt = cnt + 1'b1;
            end
          end
        end
        ST_DECODE: begin
          stb.latchAddr = 1'b1;
          stb.loadOut   = hdrIsRead;
          nState        = hdrIsRead ? ST_RDATA : ST_WDATA;
        end
        ST_WDATA: begin
          if (stbRise) begin
            stb.shiftIn  = 1'b1;
            stb.shiftOut = 1'b1;
            if (cnt == DATA_LAST) begin
              nCnt   = '0;
              nState = ST_COMMIT;
            end else begin
              nCnt = cnt + 1'b1;
            end
          end
        end
        ST_COMMIT: begin
          stb.wrEn = 1'b1;
          nState   = ST_HDR;
        end
        ST_RDATA: begin
          if (stbRise) begin
            // first data edge keeps the MSB on the line
            stb.shiftOut = (cnt != '0);
            if (cnt == DATA_LAST) begin
              nCnt   = '0;
              nState = ST_HDR;
            end else begin
              nCnt = cnt + 1'b1;
            end
          end
        end
        default: begin
          nState = ST_HDR;
          nCnt   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_HDR;
      cnt   <= '0;
    end else begin
      state <= nState;
      cnt   <= nCnt;
    end
  end

endmodule

// File: rtl/strobe_reg_dpath.sv
module strobe_reg_dpath
  import strobe_reg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic              dataBit,
  input  logic [DATA_W-1:0] rdData,
  output logic              hdrIsRead,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              dataOut
);

  logic [DATA_W-1:0] inSh;
  logic [DATA_W-1:0] outSh;
  logic [ADDR_W-1:0] addrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             inSh <= '0;
    else if (stb.clearAll) inSh <= '0;
    else if (stb.shiftIn)  inSh <= {inSh[DATA_W-2:0], dataBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              addrReg <= '0;
    else if (stb.clearAll)  addrReg <= '0;
    else if (stb.latchAddr) addrReg <= inSh[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outSh <= '0;
    else if (stb.clearAll) outSh <= '0;
    else if (stb.loadOut)  outSh <= rdData;
    else if (stb.shiftOut) outSh <= {outSh[DATA_W-2:0], 1'b0};
  end

  assign hdrIsRead = inSh[ADDR_W];
  assign busAddr   = stb.latchAddr ? inSh[ADDR_W-1:0] : addrReg;
  assign wrData    = inSh;
  assign dataOut   = outSh[DATA_W-1];

endmodule

// File: rtl/strobe_reg_file.sv
module strobe_reg_file #(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 16,
  parameter int NUM_RW  = 4,
  parameter int RW_BASE = 2,
  parameter logic [7:0]        MFG_ID   = 8'h5A,
  parameter logic [DATA_W-9:0] BOARD_ID = 'h02,
  parameter logic [3:0] FW_BUILD = 4'h3,
  parameter logic [3:0] FW_MAJOR = 4'h1,
  parameter logic [3:0] FW_MINOR = 4'h4,
  parameter logic [3:0] FW_PATCH = 4'h2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [DATA_W-1:0] PLAT_WORD = {BOARD_ID, MFG_ID};
  localparam logic [DATA_W-1:0] FW_WORD   =
    DATA_W'({FW_BUILD, FW_MAJOR, FW_MINOR, FW_PATCH});
  localparam logic [ADDR_W-1:0] PLAT_ADDR = '0;
  localparam logic [ADDR_W-1:0] FW_ADDR   = ADDR_W'(1);

  logic [DATA_W-1:0] rwRegs [NUM_RW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RW; i++) rwRegs[i] <= '0;
    end else if (wrEn) begin
      for (int i = 0; i < NUM_RW; i++) begin
        if (busAddr == ADDR_W'(RW_BASE + i)) rwRegs[i] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (busAddr == PLAT_ADDR)    rdData = PLAT_WORD;
    else if (busAddr == FW_ADDR) rdData = FW_WORD;
    for (int i = 0; i < NUM_RW; i++) begin
      if (busAddr == ADDR_W'(RW_BASE + i)) rdData = rwRegs[i];
    end
  end

endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave
  import strobe_reg_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int NUM_RW     = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic clearIn,
  input  logic strobeIn,
  input  logic dataIn,
  output logic dataOut
);

  localparam int HDR_BITS = ADDR_W + 1;

  logic [2:0]        syncLines;
  logic              sClr, sStb, sDat;
  logic              stbPrev, stbRise;
  logic              hdrIsRead;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] wrData, rdData;
  ctrlStrobe_t       ctrlStb;
  logic              wrPulse, loadPulse;

  strobe_reg_sync #(.LINES(3), .STAGES(SYNC_DEPTH)) sync_i (
    .clk(clk), .rstN(rstN),
    .asyncIn({clearIn, strobeIn, dataIn}),
    .syncOut(syncLines)
  );
  assign {sClr, sStb, sDat} = syncLines;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbPrev <= 1'b0;
    else       stbPrev <= sStb;
  end
  assign stbRise = sStb & ~stbPrev;

  strobe_reg_ctrl #(.HDR_BITS(HDR_BITS), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .clearLvl(sClr), .stbRise(stbRise),
    .hdrIsRead(hdrIsRead), .stb(ctrlStb)
  );

  strobe_reg_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .dataBit(sDat), .rdData(rdData),
    .hdrIsRead(hdrIsRead), .busAddr(busAddr), .wrData(wrData), .dataOut(dataOut)
  );

  strobe_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RW(NUM_RW)) regs_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(ctrlStb.wrEn),
    .wrData(wrData), .rdData(rdData)
  );

  assign wrPulse   = ctrlStb.wrEn;
  assign loadPulse = ctrlStb.loadOut;

endmodule

// File: rtl/strobe_reg_checker.sv
module strobe_reg_checker (
  input logic clk,
  input logic rstN,
  input logic sClr,
  input logic stbRise,
  input logic wrPulse,
  input logic loadPulse,
  input logic dataOut
);

  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |=> !wrPulse);

  assert_wr_after_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |-> $past(stbRise));

  assert_load_after_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |-> $past(stbRise));

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!stbRise && !loadPulse && !sClr) |=> $stable(dataOut));

  assert_clear_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    sClr |-> (!wrPulse && !loadPulse));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    sClr |=> !dataOut);

endmodule

bind strobe_reg_slave strobe_reg_checker chk_i (
  .clk(clk), .rstN(rstN), .sClr(sClr), .stbRise(stbRise),
  .wrPulse(wrPulse), .loadPulse(loadPulse), .dataOut(dataOut)
);

// File: tb/strobe_reg_slave_tb_top.sv
module strobe_reg_slave_tb_top;

  localparam int HALF  = 6;
  localparam int NVEC  = 21;
  localparam int LIMIT = 100000;

  // {isRead, addr[6:0], writeData[15:0], expectRead[15:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {1'b1, 7'd0,  16'h0000, 16'h025A},
    {1'b1, 7'd1,  16'h0000, 16'h3142},
    {1'b1, 7'd2,  16'h0000, 16'h0000},
    {1'b1, 7'd6,  16'h0000, 16'h0000},
    {1'b0, 7'd2,  16'hA5C3, 16'h0000},
    {1'b1, 7'd2,  16'h0000, 16'hA5C3},
    {1'b0, 7'd5,  16'hFFFF, 16'h0000},
    {1'b1, 7'd5,  16'h0000, 16'hFFFF},
    {1'b0, 7'd3,  16'h8001, 16'h0000},
    {1'b1, 7'd3,  16'h0000, 16'h8001},
    {1'b0, 7'd0,  16'h1234, 16'h0000},
    {1'b1, 7'd0,  16'h0000, 16'h025A},
    {1'b0, 7'd1,  16'h0000, 16'h0000},
    {1'b1, 7'd1,  16'h0000, 16'h3142},
    {1'b0, 7'd7,  16'hBEEF, 16'h0000},
    {1'b1, 7'd7,  16'h0000, 16'h0000},
    {1'b1, 7'd2,  16'h0000, 16'hA5C3},
    {1'b0, 7'd4,  16'h5AA5, 16'h0000},
    {1'b1, 7'd4,  16'h0000, 16'h5AA5},
    {1'b0, 7'd4,  16'h0000, 16'h0000},
    {1'b1, 7'd4,  16'h0000, 16'h0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearIn = 1'b0;
  logic strobeIn = 1'b0;
  logic dataIn = 1'b0;
  logic dataOut;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  strobe_reg_slave dut_i (
    .clk(clk), .rstN(rstN), .clearIn(clearIn),
    .strobeIn(strobeIn), .dataIn(dataIn), .dataOut(dataOut)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edgeBit(input logic b);
    strobeIn = 1'b0;
    dataIn   = b;
    waitClk(HALF);
    strobeIn = 1'b1;
    waitClk(HALF);
  endtask

  task automatic sendHeader(input logic isRead, input logic [6:0] addr);
    edgeBit(isRead);
    for (int i = 6; i >= 0; i--) edgeBit(addr[i]);
  endtask

  task automatic writeReg(input logic [6:0] addr, input logic [15:0] data);
    sendHeader(1'b0, addr);
    for (int i = 15; i >= 0; i--) edgeBit(data[i]);
    waitClk(4);
  endtask

  task automatic readData(output logic [15:0] val);
    for (int i = 15; i >= 0; i--) begin
      edgeBit(1'b0);
      val[i] = dataOut;
    end
  endtask

  task automatic readReg(input logic [6:0] addr, output logic [15:0] val);
    sendHeader(1'b1, addr);
    readData(val);
  endtask

  task automatic clearPulse();
    strobeIn = 1'b0;
    clearIn  = 1'b1;
    waitClk(HALF);
    clearIn  = 1'b0;
    waitClk(HALF);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > LIMIT) begin
        nFail++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] rd;
    string tag;

    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    check("R1 dataOut after reset", {15'b0, dataOut}, 16'h0000);

    // vector table: R2..R6 through ordinary frames
    for (int v = 0; v < NVEC; v++) begin
      logic        isRd;
      logic [6:0]  a;
      logic [15:0] wd, ex;
      {isRd, a, wd, ex} = VEC[v];
      if (isRd) begin
        readReg(a, rd);
        if (a < 7'd2)      tag = "R5/R6 id register";
        else if (a > 7'd5) tag = "R6 unmapped address";
        else               tag = "R1/R2/R3/R4 scratch register";
        check(tag, rd, ex);
      end else begin
        writeReg(a, wd);
      end
    end

    // R2: dataIn flips while strobe is high, after the edge
    sendHeader(1'b0, 7'd4);
    for (int i = 15; i >= 0; i--) begin
      logic b;
      b = 1'(16'h6C39 >> i);
      strobeIn = 1'b0;
      dataIn   = b;
      waitClk(HALF);
      strobeIn = 1'b1;
      waitClk(4);
      dataIn   = ~b;
      waitClk(HALF - 4);
    end
    waitClk(4);
    readReg(7'd4, rd);
    check("R2 data change while strobe high ignored", rd, 16'h6C39);

    // R7: partial write discarded by clear
    sendHeader(1'b0, 7'd3);
    for (int i = 0; i < 5; i++) edgeBit(1'b1);
    clearPulse();
    readReg(7'd3, rd);
    check("R7 partial write discarded", rd, 16'h8001);

    // R7: partial read, clear forces zero and blocks strobes
    sendHeader(1'b1, 7'd5);
    for (int i = 0; i < 3; i++) edgeBit(1'b0);
    check("R4 partial read bit", {15'b0, dataOut}, 16'h0001);
    strobeIn = 1'b0;
    clearIn  = 1'b1;
    waitClk(HALF);
    check("R7 dataOut zero during clear", {15'b0, dataOut}, 16'h0000);
    for (int i = 0; i < 5; i++) edgeBit(1'b1);
    check("R7 strobes ignored during clear", {15'b0, dataOut}, 16'h0000);
    strobeIn = 1'b0;
    waitClk(HALF);
    clearIn = 1'b0;
    waitClk(HALF);
    readReg(7'd5, rd);
    check("R7 framing realigned after clear", rd, 16'hFFFF);

    // R4: bit 15 valid right after header; R8: idle then new frame
    sendHeader(1'b1, 7'd2);
    check("R4 bit15 valid after address", {15'b0, dataOut}, 16'h0001);
    readData(rd);
    check("R4 full read", rd, 16'hA5C3);
    edgeBit(1'b1);
    check("R8 extra strobe shifts zero", {15'b0, dataOut}, 16'h0000);
    for (int i = 6; i >= 0; i--) edgeBit(1'(7'd3 >> i));
    readData(rd);
    check("R8 next frame after idle", rd, 16'h8001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule